// File: doc/BRIEF.md
# Processor Identification Response Unit

This unit answers an identification query from a processor core. The core raises a one-cycle request with a 32-bit leaf selector. The unit holds the selector and stays busy for a fixed number of clocks that depends on the leaf. It then presents four 32-bit result words together with a one-cycle done pulse. The result words stay unchanged until the next done pulse.

Leaf 0 returns the highest leaf the unit supports and a 12-character vendor name. The name is split over three of the result words. Leaf 1 returns a packed signature word and a feature word. The vendor text, the stepping, model and family codes, and every feature bit are elaboration parameters. Any other leaf returns all-zero results, so simulation stays deterministic.

The unit also holds the identification bit of the processor flags word, bit 21. Software writes that bit and reads it back. If the value it wrote is held, software knows the query is present.

Top module: `cpuid_unit`

## Requirements
- R1: For leaf 0, `res_a` equals 1, the highest supported leaf.
- R2: For leaf 0, the vendor text is cut into three 4-character pieces, each packed with its first character in bits 7:0. The first piece goes to `res_b`, the second to `res_d` and the third to `res_c`. The default text "OpenCoreUnit" gives `res_b`=6E65704Fh, `res_d`=65726F43h and `res_c`=74696E55h.
- R3: For leaf 1, `res_a` carries stepping in bits 3:0, model in bits 7:4 and family in bits 11:8, and bits 31:12 are zero. The defaults are stepping 3, model 2 and family 5, which give 00000523h.
- R4: For leaf 1, `res_d` is the feature word, and `res_b` and `res_c` are zero. The feature bits are: bit 0 on-chip floating point, bit 1 virtual-mode extensions, bits 6:2 a parameter field, bit 7 machine-check, bit 8 8-byte compare-exchange, and bit 9 on-chip interrupt controller. Bits 31:10 are zero. The defaults give 00000183h.
- R5: For any leaf above 1, including leaves that differ from 0 or 1 only in their upper bits, all four result words are zero.
- R6: `done` rises exactly 14 clocks after the clock edge that accepts a leaf-1 request.
- R7: `done` rises exactly 9 clocks after the clock edge that accepts a request for any other leaf.
- R8: `done` lasts one cycle. `busy` is high from the cycle after acceptance until the done pulse, and it is low during the done cycle.
- R9: A request raised while `busy` is high is ignored. It does not restart the latency and does not change the results of the pending query.
- R10: A cycle with `flag_wr_en` high stores `flag_wr_bit`, and `id_flag` shows the stored value from the next cycle on. Without `flag_wr_en`, the stored value holds.
- R11: After reset, `busy`, `done` and `id_flag` are low and all four result words are zero.
- R12: Between done pulses, the four result words hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Query request strobe |
| req_leaf | input | 32 | Leaf selector of the query |
| flag_wr_en | input | 1 | Write strobe for the identification bit |
| flag_wr_bit | input | 1 | Value written to the identification bit |
| id_flag | output | 1 | Stored identification bit (bit 21 of the flags word) |
| busy | output | 1 | A query is pending |
| done | output | 1 | One-cycle pulse: the result words are new |
| res_a | output | 32 | First result word |
| res_b | output | 32 | Second result word |
| res_c | output | 32 | Third result word |
| res_d | output | 32 | Fourth result word |

## Verification
The leaf decode is driven with 0, 1, 2, all-ones, 80000000h, 00000100h and 00010001h.

- Leaves 0 and 1 show whether the vendor pieces land in the right words and whether the signature and feature fields are placed correctly.
- The large leaves and the leaves with only upper bits set catch a decoder that looks at a truncated selector.
- The measured latency of every query separates the 14-clock leaf from the 9-clock leaves.

A second request injected mid-query shows whether a busy unit restarts or is overwritten. The identification bit is written both ways and then left alone to confirm it holds its value.

// File: rtl/cpuid_pkg.sv
package cpuid_pkg;

    localparam int WORD_W     = 32;
    localparam int VENDOR_W   = 96;
    localparam int ID_FLAG_POS = 21;
    localparam logic [WORD_W-1:0] TOP_LEAF = 32'd1;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] c;
        logic [WORD_W-1:0] d;
    } idq_words_t;

    typedef enum logic [1:0] {
        LEAF_VENDOR = 2'd0,
        LEAF_INFO   = 2'd1,
        LEAF_NONE   = 2'd2
    } leaf_kind_t;

    function automatic leaf_kind_t classify_leaf(input logic [WORD_W-1:0] sel);
        if (sel == 32'd0)      return LEAF_VENDOR;
        else if (sel == 32'd1) return LEAF_INFO;
        else                   return LEAF_NONE;
    endfunction

    // Piece k of the text, first character in the low byte.
    function automatic logic [WORD_W-1:0] text_piece(input logic [VENDOR_W-1:0] txt,
                                                     input int k);
        logic [WORD_W-1:0] w;
        for (int i = 0; i < 4; i++) begin
            w[8*i +: 8] = txt[VENDOR_W-1-8*(4*k+i) -: 8];
        end
        return w;
    endfunction

endpackage

// File: rtl/cpuid_leaf_rom.sv
module cpuid_leaf_rom
    import cpuid_pkg::*;
#(
    parameter logic [VENDOR_W-1:0] VENDOR_TEXT = "OpenCoreUnit",
    parameter logic [3:0] STEPPING  = 4'd3,
    parameter logic [3:0] MODEL     = 4'd2,
    parameter logic [3:0] FAMILY    = 4'd5,
    parameter logic       HAS_FPU   = 1'b1,
    parameter logic       HAS_VME   = 1'b1,
    parameter logic [4:0] MID_FEAT  = 5'd0,
    parameter logic       HAS_MCE   = 1'b1,
    parameter logic       HAS_CX8   = 1'b1,
    parameter logic       HAS_APIC  = 1'b0
) (
    input  logic [WORD_W-1:0] leaf,
    output idq_words_t        words
);
    localparam logic [WORD_W-1:0] SIG_WORD =
        {20'd0, FAMILY, MODEL, STEPPING};
    localparam logic [WORD_W-1:0] FEAT_WORD =
        {22'd0, HAS_APIC, HAS_CX8, HAS_MCE, MID_FEAT, HAS_VME, HAS_FPU};

    logic [WORD_W-1:0] piece [3];

    generate
        for (genvar k = 0; k < 3; k++) begin : g_piece
            assign piece[k] = text_piece(VENDOR_TEXT, k);
        end
    endgenerate

    always_comb begin
        words = '0;
        unique case (classify_leaf(leaf))
            LEAF_VENDOR: begin
                words.a = TOP_LEAF;
                words.b = piece[0];
                words.d = piece[1];
                words.c = piece[2];
            end
            LEAF_INFO: begin
                words.a = SIG_WORD;
                words.d = FEAT_WORD;
            end
            default: words = '0;
        endcase
    end
endmodule

// File: rtl/cpuid_timer.sv
module cpuid_timer #(
    parameter int LAT_INFO  = 14,
    parameter int LAT_OTHER = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_info,
    output logic busy,
    output logic finishing,
    output logic fire
);
    localparam int MAX_LAT = (LAT_INFO > LAT_OTHER) ? LAT_INFO : LAT_OTHER;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam logic [CNT_W-1:0] LOAD_INFO  = CNT_W'(LAT_INFO - 1);
    localparam logic [CNT_W-1:0] LOAD_OTHER = CNT_W'(LAT_OTHER - 1);

    logic [CNT_W-1:0] remain;

    assign finishing = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            fire   <= 1'b0;
            remain <= '0;
        end else begin
            fire <= 1'b0;
            if (busy) begin
                if (remain == '0) begin
                    busy <= 1'b0;
                    fire <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end else if (start) begin
                busy   <= 1'b1;
                remain <= is_info ? LOAD_INFO : LOAD_OTHER;
            end
        end
    end
endmodule

// File: rtl/cpuid_flag_reg.sv
module cpuid_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (wr_en) flag <= wr_bit;
    end
endmodule

// File: rtl/cpuid_unit.sv
module cpuid_unit
    import cpuid_pkg::*;
#(
    parameter logic [VENDOR_W-1:0] VENDOR_TEXT = "OpenCoreUnit",
    parameter logic [3:0] STEPPING  = 4'd3,
    parameter logic [3:0] MODEL     = 4'd2,
    parameter logic [3:0] FAMILY    = 4'd5,
    parameter logic       HAS_FPU   = 1'b1,
    parameter logic       HAS_VME   = 1'b1,
    parameter logic [4:0] MID_FEAT  = 5'd0,
    parameter logic       HAS_MCE   = 1'b1,
    parameter logic       HAS_CX8   = 1'b1,
    parameter logic       HAS_APIC  = 1'b0,
    parameter int         LAT_INFO  = 14,
    parameter int         LAT_OTHER = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_leaf,
    input  logic        flag_wr_en,
    input  logic        flag_wr_bit,
    output logic        id_flag,
    output logic        busy,
    output logic        done,
    output logic [31:0] res_a,
    output logic [31:0] res_b,
    output logic [31:0] res_c,
    output logic [31:0] res_d
);
    logic              accept;
    logic              finishing;
    logic [WORD_W-1:0] leaf_q;
    idq_words_t        decoded;
    idq_words_t        out_q;

    assign accept = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst)         leaf_q <= '0;
        else if (accept) leaf_q <= req_leaf;
    end

    cpuid_leaf_rom #(
        .VENDOR_TEXT(VENDOR_TEXT), .STEPPING(STEPPING), .MODEL(MODEL),
        .FAMILY(FAMILY), .HAS_FPU(HAS_FPU), .HAS_VME(HAS_VME),
        .MID_FEAT(MID_FEAT), .HAS_MCE(HAS_MCE), .HAS_CX8(HAS_CX8),
        .HAS_APIC(HAS_APIC)
    ) u_rom (
        .leaf  (leaf_q),
        .words (decoded)
    );

    cpuid_timer #(.LAT_INFO(LAT_INFO), .LAT_OTHER(LAT_OTHER)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .is_info   (classify_leaf(req_leaf) == LEAF_INFO),
        .busy      (busy),
        .finishing (finishing),
        .fire      (done)
    );

    cpuid_flag_reg u_flag (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (flag_wr_en),
        .wr_bit (flag_wr_bit),
        .flag   (id_flag)
    );

    always_ff @(posedge clk) begin
        if (rst)            out_q <= '0;
        else if (finishing) out_q <= decoded;
    end

    assign res_a = out_q.a;
    assign res_b = out_q.b;
    assign res_c = out_q.c;
    assign res_d = out_q.d;
endmodule

// File: rtl/cpuid_unit_chk.sv
module cpuid_unit_chk #(
    parameter int LAT_INFO  = 14,
    parameter int LAT_OTHER = 9
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_leaf,
    input logic        flag_wr_en,
    input logic        flag_wr_bit,
    input logic        id_flag,
    input logic        busy,
    input logic        done,
    input logic [31:0] res_a,
    input logic [31:0] res_b,
    input logic [31:0] res_c,
    input logic [31:0] res_d
);
    logic [31:0] seen_leaf;
    logic [31:0] elapsed;
    logic [31:0] want_lat;
    logic        tracking;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_leaf <= '0;
            elapsed   <= '0;
            want_lat  <= '0;
            tracking  <= 1'b0;
        end else if (req_valid && !busy) begin
            seen_leaf <= req_leaf;
            elapsed   <= '0;
            want_lat  <= (req_leaf == 32'd1) ? LAT_INFO : LAT_OTHER;
            tracking  <= 1'b1;
        end else if (tracking) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // R1
    leaf0_top_chk: assert property (@(posedge clk) disable iff (rst)
        done && seen_leaf == 32'd0 |-> res_a == 32'd1);
    // R3
    leaf1_sig_hi_chk: assert property (@(posedge clk) disable iff (rst)
        done && seen_leaf == 32'd1 |-> res_a[31:12] == 20'd0);
    // R4
    leaf1_feat_chk: assert property (@(posedge clk) disable iff (rst)
        done && seen_leaf == 32'd1 |-> res_b == 32'd0 && res_c == 32'd0 && res_d[31:10] == 22'd0);
    // R5
    leaf_undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done && seen_leaf > 32'd1 |-> (res_a | res_b | res_c | res_d) == 32'd0);
    // R6 R7
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> tracking && elapsed == want_lat);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> busy || done);
    // R10
    flag_store_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(flag_wr_en) |-> id_flag == $past(flag_wr_bit));
    // R10
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(flag_wr_en) |-> $stable(id_flag));
    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({res_a, res_b, res_c, res_d}));
endmodule

bind cpuid_unit cpuid_unit_chk #(.LAT_INFO(LAT_INFO), .LAT_OTHER(LAT_OTHER)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_leaf(req_leaf),
    .flag_wr_en(flag_wr_en), .flag_wr_bit(flag_wr_bit), .id_flag(id_flag),
    .busy(busy), .done(done), .res_a(res_a), .res_b(res_b), .res_c(res_c),
    .res_d(res_d)
);

// File: tb/cpuid_unit_bench.sv
`timescale 1ns/1ps
module cpuid_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_leaf = '0;
    logic        flag_wr_en = 1'b0;
    logic        flag_wr_bit = 1'b0;
    logic        id_flag, busy, done;
    logic [31:0] res_a, res_b, res_c, res_d;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    cpuid_unit u_cpuid_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_leaf(req_leaf),
        .flag_wr_en(flag_wr_en), .flag_wr_bit(flag_wr_bit), .id_flag(id_flag),
        .busy(busy), .done(done), .res_a(res_a), .res_b(res_b),
        .res_c(res_c), .res_d(res_d)
    );

    // {leaf, a, b, c, d, latency}
    localparam int NVEC = 7;
    localparam logic [191:0] VEC [NVEC] = '{
        {32'h0000_0000, 32'h0000_0001, 32'h6E65_704F, 32'h7469_6E55, 32'h6572_6F43, 32'd9},
        {32'h0000_0001, 32'h0000_0523, 32'h0, 32'h0, 32'h0000_0183, 32'd14},
        {32'h0000_0002, 32'h0, 32'h0, 32'h0, 32'h0, 32'd9},
        {32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'd9},
        {32'h8000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'd9},
        {32'h0000_0100, 32'h0, 32'h0, 32'h0, 32'h0, 32'd9},
        {32'h0001_0001, 32'h0, 32'h0, 32'h0, 32'h0, 32'd9}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        tests++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, want);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Issue a query; optionally inject a second request at step inj_at.
    task automatic run_query(input logic [31:0] leaf, input int inj_at,
                             input logic [31:0] inj_leaf, output int n,
                             output logic busy_ok);
        @(negedge clk);
        req_valid = 1'b1;
        req_leaf  = leaf;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        busy_ok = 1'b1;
        while (!done && n < 200) begin
            if (!busy) busy_ok = 1'b0;
            if (n == inj_at) begin
                req_valid = 1'b1;
                req_leaf  = inj_leaf;
            end
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        summary();
    end

    initial begin
        int n;
        logic bok;
        logic [31:0] ha, hb, hc, hd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check("R11 busy", {31'd0, busy}, 32'd0);
        check("R11 done", {31'd0, done}, 32'd0);
        check("R11 id_flag", {31'd0, id_flag}, 32'd0);
        check("R11 results", res_a | res_b | res_c | res_d, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] lf, ea, eb, ec, ed, el;
            {lf, ea, eb, ec, ed, el} = VEC[v];
            run_query(lf, -1, 32'd0, n, bok);
            // R6 (leaf 1) / R7 (others)
            check(lf == 32'd1 ? "R6 latency" : "R7 latency", n, el);
            check("R8 busy until done", {31'd0, bok}, 32'd1);
            check("R8 busy low at done", {31'd0, busy}, 32'd0);
            // R1 R3 R5 first word; R2 R4 R5 remaining words
            check(lf == 0 ? "R1 res_a" : (lf == 1 ? "R3 res_a" : "R5 res_a"), res_a, ea);
            check(lf == 0 ? "R2 res_b" : (lf == 1 ? "R4 res_b" : "R5 res_b"), res_b, eb);
            check(lf == 0 ? "R2 res_c" : (lf == 1 ? "R4 res_c" : "R5 res_c"), res_c, ec);
            check(lf == 0 ? "R2 res_d" : (lf == 1 ? "R4 res_d" : "R5 res_d"), res_d, ed);
            @(negedge clk);
            check("R8 done single cycle", {31'd0, done}, 32'd0);
        end

        // R12 results hold while idle
        ha = res_a; hb = res_b; hc = res_c; hd = res_d;
        repeat (6) @(negedge clk);
        check("R12 hold a", res_a, ha);
        check("R12 hold d", res_d ^ hb ^ hc, hd ^ hb ^ hc);

        // R9 request while busy is ignored
        run_query(32'd1, 3, 32'd0, n, bok);
        check("R9 latency not restarted", n, 32'd14);
        check("R9 result from first query", res_a, 32'h0000_0523);
        check("R9 feature word kept", res_d, 32'h0000_0183);
        begin
            int extra = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R9 no second done", extra, 32'd0);
        end
        run_query(32'd0, 7, 32'd1, n, bok);
        check("R9 late inject latency", n, 32'd9);
        check("R9 late inject result", res_b, 32'h6E65_704F);

        // R10 identification bit
        @(negedge clk);
        flag_wr_en = 1'b1; flag_wr_bit = 1'b1;
        @(negedge clk);
        flag_wr_en = 1'b0; flag_wr_bit = 1'b0;
        check("R10 set", {31'd0, id_flag}, 32'd1);
        repeat (4) @(negedge clk);
        check("R10 hold without write", {31'd0, id_flag}, 32'd1);
        flag_wr_en = 1'b1; flag_wr_bit = 1'b0;
        @(negedge clk);
        flag_wr_en = 1'b0; flag_wr_bit = 1'b1;
        check("R10 clear", {31'd0, id_flag}, 32'd0);
        @(negedge clk);
        check("R10 data without strobe", {31'd0, id_flag}, 32'd0);

        // R11 reset mid-query clears everything
        @(negedge clk);
        req_valid = 1'b1; req_leaf = 32'd0;
        @(negedge clk);
        req_valid = 1'b0;
        flag_wr_en = 1'b1; flag_wr_bit = 1'b1;
        @(negedge clk);
        flag_wr_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 busy after reset", {31'd0, busy}, 32'd0);
        check("R11 flag after reset", {31'd0, id_flag}, 32'd0);
        check("R11 results after reset", res_a | res_b | res_c | res_d, 32'd0);

        summary();
    end
endmodule